// File: doc/BRIEF.md
# Reorder Buffer with Register Alias Table

This block keeps the instructions of a small out-of-order core in program order between dispatch and retirement. Every dispatched instruction takes the next slot of an eight-slot ring and receives that slot index as its tag. Execution units return results out of order, each tagged with its slot. The oldest slot leaves the ring only after its result has arrived. At that point it writes the register file, writes memory, or does nothing if it is a branch.

An alias table sits beside the ring. For each architectural register it holds the tag of the youngest in-flight producer of that register. A lookup port gives the dispatch stage the pending flag and the tag. When the producer has already finished, the same port also returns its ready flag and value.

A mispredicted branch is reported by its tag. Every younger slot is then dropped. An exception carried by a result takes effect only when its slot reaches the head. At that point nothing is committed, the exception is signalled and the whole buffer is emptied.

Top module: `rob_core`

## Requirements
- R1: Dispatch takes slots in program order. The tag given (`disp_tag`) is the slot index, which counts up from 0 after reset and wraps modulo 8. `disp_ready` is low while all 8 slots are in use, and a dispatch offered while `disp_ready` is low changes nothing. Kind encoding on `disp_kind`: 2'b00 register write, 2'b01 store, 2'b10 branch.
- R2: A completion with tag T stores the value and exception flag into slot T and marks it ready. For a store, the completion also supplies the memory address.
- R3: Only the oldest slot retires, and only once it is ready. At most one slot retires per cycle. Slots retire in dispatch order regardless of the order in which they complete.
- R4: `flush_valid` with tag B discards every slot younger than B and keeps B and older slots. The next dispatch then receives tag B+1. A dispatch offered in the flush cycle is ignored.
- R5: A ready head slot carrying an exception asserts `exc_valid` with `ret_tag` for one cycle and writes neither the register file nor memory. It then empties the buffer and the alias table, and the next dispatch receives tag 0.
- R6: A lookup of register R returns whether a producer is pending and the tag of its youngest producer. When that producer is ready, the lookup also returns the ready flag and its value.
- R7: Retirement clears a register's mapping only when the mapping still names the retiring slot. A flush clears the mappings that name discarded slots.
- R8: A retiring register-write slot pulses `rf_we` with its register and value. A retiring store pulses `mem_we` with its address and value. A retiring branch pulses neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Instruction kind (00 reg, 01 store, 10 branch) |
| disp_reg | input | 4 | Destination register for register writes |
| disp_ready | output | 1 | A slot can be taken this cycle |
| disp_tag | output | 3 | Tag the next dispatch receives |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 3 | Slot being completed |
| cmp_value | input | 32 | Result value or store data |
| cmp_addr | input | 32 | Store address |
| cmp_excp | input | 1 | Result carries an exception |
| flush_valid | input | 1 | Mispredicted branch report |
| flush_tag | input | 3 | Tag of the mispredicted branch |
| look_reg | input | 4 | Register being looked up |
| look_pend | output | 1 | A producer of look_reg is in flight |
| look_tag | output | 3 | Tag of the youngest producer |
| look_ready | output | 1 | That producer has its result |
| look_value | output | 32 | That producer's result |
| ret_valid | output | 1 | Head slot leaves this cycle |
| ret_tag | output | 3 | Tag of the leaving slot |
| exc_valid | output | 1 | Leaving slot raises its exception |
| rf_we | output | 1 | Register file write strobe |
| rf_reg | output | 4 | Register file write index |
| rf_data | output | 32 | Register file write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |

## Verification
Assertions check three structural properties on every cycle: the slot count stays bounded and matches the distance between the pointers, every live alias mapping names a slot inside the occupied range, and consecutive retirements advance the tag by one. They also check that a flush rewinds the tail right behind the branch and that an exception leaves the buffer empty. Only the bench scenarios can show the values that end up written to the register file and memory. The same holds for the stall and wrap behaviour at full occupancy, for branches retiring silently, and for the loss of completed but younger work after an exception or a misprediction. The bench covers these by comparing every retirement against a scoreboard of expected slots.

// File: rtl/rob_pkg.sv
package rob_pkg;

    parameter int DATA_W = 32;
    parameter int ADDR_W = 32;

    typedef enum logic [1:0] {
        KIND_REG    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10
    } kind_t;

    // One slot of the ring. dest holds a register index for register
    // writes and the memory address for stores (filled at completion).
    typedef struct packed {
        kind_t             kind;
        logic [ADDR_W-1:0] dest;
        logic [DATA_W-1:0] value;
        logic              ready;
        logic              excp;
    } rob_entry_t;

    function automatic logic is_reg_write(input kind_t k);
        return k == KIND_REG;
    endfunction

    function automatic logic is_store(input kind_t k);
        return k == KIND_STORE;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int CNT_W   = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             advance,
    input  logic             flush,
    input  logic [IDX_W-1:0] flush_tag,
    input  logic             clear_all,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [IDX_W-1:0] head_n;
    logic [IDX_W-1:0] tail_n;
    logic [CNT_W-1:0] count_n;
    logic [IDX_W-1:0] flush_age;

    assign flush_age = flush_tag - head;

    always_comb begin
        head_n  = head;
        tail_n  = tail;
        count_n = count;
        if (clear_all) begin
            head_n  = '0;
            tail_n  = '0;
            count_n = '0;
        end else begin
            if (advance) begin
                head_n = head + 1'b1;
            end
            if (flush) begin
                tail_n  = flush_tag + 1'b1;
                count_n = CNT_W'(flush_age) + 1'b1 - CNT_W'(advance);
            end else begin
                if (alloc) begin
                    tail_n = tail + 1'b1;
                end
                count_n = count + CNT_W'(alloc) - CNT_W'(advance);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= head_n;
            tail  <= tail_n;
            count <= count_n;
        end
    end

    assign full  = (count == CNT_W'(ENTRIES));
    assign empty = (count == '0);

    // R1: occupancy never exceeds the ring size
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ENTRIES));

    // R1: the tail always sits count slots past the head
    a_r1_ptr_track: assert property (@(posedge clk) disable iff (rst)
        tail == IDX_W'(head + count[IDX_W-1:0]));

    // R4: a flush places the tail directly behind the branch
    a_r4_flush_tail: assert property (@(posedge clk) disable iff (rst)
        (flush && !clear_all) |=> tail == IDX_W'($past(flush_tag) + 1'b1));

endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  kind_t             alloc_kind,
    input  logic [ADDR_W-1:0] alloc_dest,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_value,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              cmp_excp,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output rob_entry_t        rd_a,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output rob_entry_t        rd_b
);

    rob_entry_t slot [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= '0;
            end else if (alloc && alloc_idx == IDX_W'(i)) begin
                slot[i] <= '{kind: alloc_kind, dest: alloc_dest,
                             value: '0, ready: 1'b0, excp: 1'b0};
            end else if (cmp_valid && cmp_idx == IDX_W'(i)) begin
                slot[i].value <= cmp_value;
                slot[i].ready <= 1'b1;
                slot[i].excp  <= cmp_excp;
                if (is_store(slot[i].kind)) begin
                    slot[i].dest <= cmp_addr;
                end
            end
        end
    end

    assign rd_a = slot[rd_a_idx];
    assign rd_b = slot[rd_b_idx];

    // R2: a completion leaves its slot ready and holding the result
    a_r2_completion_lands: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !(alloc && alloc_idx == cmp_idx)) |=>
            (slot[$past(cmp_idx)].ready && slot[$past(cmp_idx)].value == $past(cmp_value)));

endmodule

// File: rtl/rob_alias.sv
module rob_alias #(
    parameter  int ENTRIES  = 8,
    parameter  int NUM_AREG = 16,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int CNT_W    = IDX_W + 1,
    localparam int AREG_W   = $clog2(NUM_AREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_all,
    input  logic              set_en,
    input  logic [AREG_W-1:0] set_reg,
    input  logic [IDX_W-1:0]  set_tag,
    input  logic              drop_en,
    input  logic [AREG_W-1:0] drop_reg,
    input  logic [IDX_W-1:0]  drop_tag,
    input  logic              flush,
    input  logic [IDX_W-1:0]  flush_tag,
    input  logic [IDX_W-1:0]  head,
    input  logic [CNT_W-1:0]  count,
    input  logic [AREG_W-1:0] look_reg,
    output logic              look_pend,
    output logic [IDX_W-1:0]  look_tag
);

    logic              pend [NUM_AREG];
    logic [IDX_W-1:0]  map  [NUM_AREG];
    logic [IDX_W-1:0]  flush_age;

    assign flush_age = flush_tag - head;

    for (genvar r = 0; r < NUM_AREG; r++) begin : g_reg
        logic [IDX_W-1:0] age_r;
        assign age_r = map[r] - head;

        always_ff @(posedge clk) begin
            if (rst || clear_all) begin
                pend[r] <= 1'b0;
                map[r]  <= '0;
            end else if (set_en && set_reg == AREG_W'(r)) begin
                pend[r] <= 1'b1;
                map[r]  <= set_tag;
            end else if (flush && pend[r] && (age_r > flush_age)) begin
                pend[r] <= 1'b0;
            end else if (drop_en && drop_reg == AREG_W'(r) && map[r] == drop_tag) begin
                pend[r] <= 1'b0;
            end
        end

        // R6: a pending mapping always names an occupied slot
        a_r6_map_live: assert property (@(posedge clk) disable iff (rst)
            pend[r] |-> (CNT_W'(age_r) < count));
    end

    assign look_pend = pend[look_reg];
    assign look_tag  = map[look_reg];

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter  int ENTRIES  = 8,
    parameter  int NUM_AREG = 16,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int CNT_W    = IDX_W + 1,
    localparam int AREG_W   = $clog2(NUM_AREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [1:0]        disp_kind,
    input  logic [AREG_W-1:0] disp_reg,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_tag,
    input  logic              cmp_valid,
    input  logic [IDX_W-1:0]  cmp_tag,
    input  logic [DATA_W-1:0] cmp_value,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              cmp_excp,
    input  logic              flush_valid,
    input  logic [IDX_W-1:0]  flush_tag,
    input  logic [AREG_W-1:0] look_reg,
    output logic              look_pend,
    output logic [IDX_W-1:0]  look_tag,
    output logic              look_ready,
    output logic [DATA_W-1:0] look_value,
    output logic              ret_valid,
    output logic [IDX_W-1:0]  ret_tag,
    output logic              exc_valid,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_reg,
    output logic [DATA_W-1:0] rf_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);

    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             empty;
    rob_entry_t       head_ent;
    rob_entry_t       look_ent;
    kind_t            new_kind;
    logic             head_ok;
    logic             exc_now;
    logic             commit;
    logic             alloc;
    logic             flush_eff;

    assign new_kind   = kind_t'(disp_kind);
    assign head_ok    = !empty && head_ent.ready;
    assign exc_now    = head_ok && head_ent.excp;
    assign commit     = head_ok && !head_ent.excp;
    assign disp_ready = !full && !flush_valid && !exc_now;
    assign alloc      = disp_valid && disp_ready;
    assign flush_eff  = flush_valid && !exc_now;
    assign disp_tag   = tail;

    rob_ptrs #(.ENTRIES(ENTRIES)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .alloc     (alloc),
        .advance   (commit),
        .flush     (flush_eff),
        .flush_tag (flush_tag),
        .clear_all (exc_now),
        .head      (head),
        .tail      (tail),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    rob_store #(.ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .alloc      (alloc),
        .alloc_idx  (tail),
        .alloc_kind (new_kind),
        .alloc_dest (ADDR_W'(disp_reg)),
        .cmp_valid  (cmp_valid),
        .cmp_idx    (cmp_tag),
        .cmp_value  (cmp_value),
        .cmp_addr   (cmp_addr),
        .cmp_excp   (cmp_excp),
        .rd_a_idx   (head),
        .rd_a       (head_ent),
        .rd_b_idx   (look_tag),
        .rd_b       (look_ent)
    );

    rob_alias #(.ENTRIES(ENTRIES), .NUM_AREG(NUM_AREG)) u_alias (
        .clk       (clk),
        .rst       (rst),
        .clear_all (exc_now),
        .set_en    (alloc && is_reg_write(new_kind)),
        .set_reg   (disp_reg),
        .set_tag   (tail),
        .drop_en   (commit && is_reg_write(head_ent.kind)),
        .drop_reg  (head_ent.dest[AREG_W-1:0]),
        .drop_tag  (head),
        .flush     (flush_eff),
        .flush_tag (flush_tag),
        .head      (head),
        .count     (count),
        .look_reg  (look_reg),
        .look_pend (look_pend),
        .look_tag  (look_tag)
    );

    assign look_ready = look_pend && look_ent.ready;
    assign look_value = look_ent.value;

    assign ret_valid = head_ok;
    assign ret_tag   = head;
    assign exc_valid = exc_now;
    assign rf_we     = commit && is_reg_write(head_ent.kind);
    assign rf_reg    = head_ent.dest[AREG_W-1:0];
    assign rf_data   = head_ent.value;
    assign mem_we    = commit && is_store(head_ent.kind);
    assign mem_addr  = head_ent.dest;
    assign mem_data  = head_ent.value;

    // R3: back-to-back retirements leave in consecutive tag order
    a_r3_in_order: assert property (@(posedge clk) disable iff (rst)
        commit |=> (!ret_valid || ret_tag == IDX_W'($past(ret_tag) + 1'b1)));

    // R5: an exception leaves the buffer empty with the tag reset
    a_r5_exc_empties: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (!ret_valid && disp_tag == '0));

endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;

    localparam logic [1:0] K_REG    = 2'b00;
    localparam logic [1:0] K_STORE  = 2'b01;
    localparam logic [1:0] K_BRANCH = 2'b10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_valid = 1'b0;
    logic [1:0]  disp_kind = 2'b00;
    logic [3:0]  disp_reg = '0;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_tag = '0;
    logic [31:0] cmp_value = '0;
    logic [31:0] cmp_addr = '0;
    logic        cmp_excp = 1'b0;
    logic        flush_valid = 1'b0;
    logic [2:0]  flush_tag = '0;
    logic [3:0]  look_reg = '0;
    logic        look_pend;
    logic [2:0]  look_tag;
    logic        look_ready;
    logic [31:0] look_value;
    logic        ret_valid;
    logic [2:0]  ret_tag;
    logic        exc_valid;
    logic        rf_we;
    logic [3:0]  rf_reg;
    logic [31:0] rf_data;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;

    int errors = 0;
    int checks = 0;
    int q[$];
    logic [1:0]  exp_kind [8];
    logic [31:0] exp_dest [8];
    logic [31:0] exp_data [8];
    logic        exp_exc  [8];
    logic [2:0]  exp_tail = '0;
    int          mon_tag;

    always #10 clk = ~clk;

    rob_core u0 (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_reg(disp_reg),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
        .cmp_addr(cmp_addr), .cmp_excp(cmp_excp),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .look_reg(look_reg), .look_pend(look_pend), .look_tag(look_tag),
        .look_ready(look_ready), .look_value(look_value),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .exc_valid(exc_valid),
        .rf_we(rf_we), .rf_reg(rf_reg), .rf_data(rf_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic dispatch(input logic [1:0] k, input logic [3:0] r);
        check("R1 ready", disp_ready, 1);
        check("R1 tag", disp_tag, exp_tail);
        disp_valid = 1'b1;
        disp_kind  = k;
        disp_reg   = r;
        exp_kind[exp_tail] = k;
        exp_dest[exp_tail] = 32'(r);
        exp_data[exp_tail] = '0;
        exp_exc[exp_tail]  = 1'b0;
        q.push_back(int'(exp_tail));
        exp_tail = exp_tail + 3'd1;
        step();
        disp_valid = 1'b0;
    endtask

    task automatic complete(input logic [2:0] t, input logic [31:0] v,
                            input logic [31:0] a, input logic e);
        cmp_valid = 1'b1;
        cmp_tag   = t;
        cmp_value = v;
        cmp_addr  = a;
        cmp_excp  = e;
        exp_data[t] = v;
        exp_exc[t]  = e;
        if (exp_kind[t] == K_STORE) exp_dest[t] = a;
        step();
        cmp_valid = 1'b0;
        cmp_excp  = 1'b0;
    endtask

    task automatic look(input logic [3:0] r, input logic p, input logic [2:0] t, input string req);
        look_reg = r;
        #1;
        check(req, look_pend, p);
        if (p) check(req, look_tag, t);
    endtask

    // Scoreboard monitor: every retirement must match the oldest expected slot
    always @(negedge clk) begin
        if (!rst && ret_valid) begin
            if (q.size() == 0) begin
                check("R3 unexpected retire", ret_tag, 8);
            end else begin
                mon_tag = q.pop_front();
                check("R3 retire order", ret_tag, mon_tag);
                if (exp_exc[mon_tag]) begin
                    check("R5 exc flag", exc_valid, 1);
                    check("R5 no rf write", rf_we, 0);
                    check("R5 no mem write", mem_we, 0);
                    q.delete();
                    exp_tail = '0;
                end else begin
                    check("R5 no exc", exc_valid, 0);
                    case (exp_kind[mon_tag])
                        K_REG: begin
                            check("R8 rf_we", rf_we, 1);
                            check("R8 rf_reg", rf_reg, exp_dest[mon_tag]);
                            check("R8 rf_data", rf_data, exp_data[mon_tag]);
                            check("R8 reg no mem", mem_we, 0);
                        end
                        K_STORE: begin
                            check("R8 mem_we", mem_we, 1);
                            check("R8 mem_addr", mem_addr, exp_dest[mon_tag]);
                            check("R8 mem_data", mem_data, exp_data[mon_tag]);
                            check("R8 store no rf", rf_we, 0);
                        end
                        default: begin
                            check("R8 branch no rf", rf_we, 0);
                            check("R8 branch no mem", mem_we, 0);
                        end
                    endcase
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        step();

        // Reset state
        check("R1 reset ready", disp_ready, 1);
        check("R1 reset tag", disp_tag, 0);
        check("R3 reset no retire", ret_valid, 0);
        look(4'd1, 1'b0, 3'd0, "R6 reset lookup");

        // Renaming: two producers of r1, one of r2
        dispatch(K_REG, 4'd1);
        dispatch(K_REG, 4'd2);
        dispatch(K_REG, 4'd1);
        look(4'd1, 1'b1, 3'd2, "R6 newest producer r1");
        look(4'd2, 1'b1, 3'd1, "R6 producer r2");

        complete(3'd2, 32'h0000_00A2, '0, 1'b0);
        look(4'd1, 1'b1, 3'd2, "R6 ready lookup");
        check("R6 look_ready", look_ready, 1);
        check("R6 look_value", look_value, 32'h0000_00A2);
        check("R3 younger ready does not retire", ret_valid, 0);

        complete(3'd0, 32'h0000_00A0, '0, 1'b0);
        step();
        look(4'd1, 1'b1, 3'd2, "R7 stale retire keeps mapping");
        complete(3'd1, 32'h0000_00A1, '0, 1'b0);
        repeat (3) step();
        look(4'd1, 1'b0, 3'd0, "R7 retire clears r1");
        look(4'd2, 1'b0, 3'd0, "R7 retire clears r2");

        // Fill all eight slots, try one more, complete in reverse
        for (int i = 0; i < 8; i++) dispatch(K_REG, 4'(8 + (i % 4)));
        check("R1 full stalls", disp_ready, 0);
        disp_valid = 1'b1;
        disp_reg   = 4'd15;
        step();
        disp_valid = 1'b0;
        check("R1 full tag unchanged", disp_tag, 3);
        look(4'd15, 1'b0, 3'd0, "R1 refused dispatch leaves no mapping");
        for (int i = 7; i >= 0; i--) complete(3'(3 + i), 32'h0000_00B0 + 32'(i), '0, 1'b0);
        repeat (10) step();
        check("R3 all retired", q.size(), 0);
        check("R1 ready after drain", disp_ready, 1);

        // Store then register write
        dispatch(K_STORE, 4'd0);
        dispatch(K_REG, 4'd7);
        complete(3'd4, 32'h0000_0C07, '0, 1'b0);
        complete(3'd3, 32'h5555_AAAA, 32'h1000_0040, 1'b0);
        repeat (3) step();

        // Misprediction flush
        dispatch(K_BRANCH, 4'd0);
        dispatch(K_REG, 4'd3);
        dispatch(K_STORE, 4'd0);
        look(4'd3, 1'b1, 3'd6, "R6 r3 before flush");
        flush_valid = 1'b1;
        flush_tag   = 3'd5;
        disp_valid  = 1'b1;
        disp_kind   = K_REG;
        disp_reg    = 4'd9;
        #1;
        check("R4 no dispatch during flush", disp_ready, 0);
        step();
        flush_valid = 1'b0;
        disp_valid  = 1'b0;
        while (q.size() > 0 && q[$] != 5) void'(q.pop_back());
        exp_tail = 3'd6;
        check("R4 tail behind branch", disp_tag, 6);
        look(4'd3, 1'b0, 3'd0, "R7 flush clears squashed mapping");
        look(4'd9, 1'b0, 3'd0, "R4 dispatch in flush ignored");
        dispatch(K_REG, 4'd4);
        complete(3'd5, 32'h0000_0BBB, '0, 1'b0);
        complete(3'd6, 32'h0000_00D6, '0, 1'b0);
        repeat (3) step();

        // Exception at the head discards finished younger work
        dispatch(K_REG, 4'd5);
        dispatch(K_REG, 4'd6);
        complete(3'd0, 32'h0000_0E06, '0, 1'b0);
        check("R3 head not ready blocks", ret_valid, 0);
        complete(3'd7, 32'h0000_0E05, '0, 1'b1);
        repeat (3) step();
        check("R5 buffer empty", ret_valid, 0);
        check("R5 tag restarts", disp_tag, 0);
        look(4'd6, 1'b0, 3'd0, "R5 alias cleared r6");
        look(4'd5, 1'b0, 3'd0, "R5 alias cleared r5");

        // Buffer works again after the exception
        exp_tail = '0;
        dispatch(K_REG, 4'd2);
        complete(3'd0, 32'h0000_00EE, '0, 1'b0);
        repeat (3) step();
        check("R3 final drain", q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule